// File: doc/BRIEF.md
# RV64 Machine/Supervisor Status and Return-PC Register Unit

This unit keeps the machine status word, its supervisor-level view, the two exception-return program counters and a read-only configuration pointer for a 64-bit RISC-V hart. CSR writes arrive on a single address/data/enable port and are legalised before they reach storage. The legal values depend on which privilege modes the parameters enable, so fields that belong to a missing mode read as zero. Reads are combinational on the same address port.

Two strobes, one for a machine-level return and one for a supervisor-level return, drive the return behaviour. In the same cycle as the strobe, the unit presents the privilege to resume and the return PC. On the following clock edge it updates the interrupt-enable stack and the previous-privilege fields. Each cycle is classified into one of three return kinds: `RET_NONE` (no return, a CSR write may be applied), `RET_M` (machine return; it wins when both strobes are high) and `RET_S` (supervisor return, possible only when S-mode exists). When any strobe is high, any CSR write in that cycle is dropped. The parameter combination with S-mode present and U-mode absent is not supported.

Privilege encoding: U = 2'b00, S = 2'b01, M = 2'b11. CSR addresses: status 0x300, supervisor status view 0x100, machine return PC 0x341, supervisor return PC 0x141, configuration pointer 0xF15. Any other address reads zero.

Top module: `csr_status_unit`

## Requirements
- R1: After reset the status word reads with MPP (bits 12:11) = 2'b11, SXL (35:34) and UXL (33:32) = 2'b10 for each supported mode, and every other bit 0. Both return PCs read 0.
- R2: While the machine-return strobe is high, ret_priv_o equals MPP and ret_pc_o equals the machine return PC. On the next edge MIE (bit 3) takes the old MPIE (bit 7), MPIE becomes 1, and MPP becomes the lowest supported mode (2'b00 if U-mode exists, else 2'b11).
- R3: MPRV (bit 17) is cleared by a machine return whose MPP is not 2'b11 and is kept when MPP is 2'b11. A supervisor return always clears it.
- R4: While the supervisor-return strobe is high and S-mode exists, ret_priv_o = {1'b0, SPP (bit 8)} and ret_pc_o equals the supervisor return PC. On the next edge SIE (bit 1) takes the old SPIE (bit 5), SPIE becomes 1, and SPP becomes 0. Without S-mode the strobe changes nothing and ret_priv_o follows priv_i.
- R5: SXL and UXL read 2'b10 when their mode is supported, and any written value leaves them unchanged. They read 2'b00 when the mode is absent.
- R6: Bit 0 of both return PCs always reads 0, whatever value is written.
- R7: The configuration pointer at 0xF15 always reads 0 and writes to it have no effect.
- R8: The byte-order control bits MBE (37), SBE (36) and UBE (6) always read 0.
- R9: Address 0x100 reads the status word masked to SD, UXL, MXR, SUM, XS, FS, SPP, SPIE and SIE. A write there changes only those bits.
- R10: SD (bit 63) reads 1 exactly when FS (14:13) or XS (16:15) is 2'b11.
- R11: A write that gives MPP an unsupported or reserved mode leaves MPP unchanged.
- R12: Without S-mode, SIE, SPIE, SPP, SUM, MXR, TVM (20) and TSR (22), the 0x100 view and the supervisor return PC all read 0. Without U-mode, MPRV reads 0.
- R13: A CSR write in a cycle with either return strobe high is dropped. When both strobes are high, the machine return is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_wdata_i | input | 64 | CSR write data |
| csr_we_i | input | 1 | CSR write enable |
| mret_i | input | 1 | Machine-level return strobe |
| sret_i | input | 1 | Supervisor-level return strobe |
| priv_i | input | 2 | Current privilege level |
| csr_rdata_o | output | 64 | CSR read data for csr_addr_i |
| ret_priv_o | output | 2 | Privilege to resume after a return, else priv_i |
| ret_pc_o | output | 64 | Return PC for the strobe being taken |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. One copy has both S-mode and U-mode enabled, the other is machine-only. The full copy exercises the return stack, MPRV clearing, the supervisor view and the widths of SXL and UXL. The machine-only copy exercises the fields that are hardwired to zero, the ignored supervisor strobe and view, and the MPP legality rule under which only machine mode is accepted.

// File: rtl/csrst_pkg.sv
package csrst_pkg;

    localparam int XLEN = 64;

    typedef enum logic [1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        RET_NONE = 2'b00,
        RET_M    = 2'b01,
        RET_S    = 2'b10
    } ret_kind_e;

    localparam logic [11:0] ADDR_MSTATUS = 12'h300;
    localparam logic [11:0] ADDR_SSTATUS = 12'h100;
    localparam logic [11:0] ADDR_MEPC    = 12'h341;
    localparam logic [11:0] ADDR_SEPC    = 12'h141;
    localparam logic [11:0] ADDR_CFGPTR  = 12'hF15;

    localparam logic [1:0] XL_64 = 2'b10;

    // Supervisor view: SD, UXL, MXR, SUM, XS, FS, SPP, SPIE, SIE
    localparam logic [XLEN-1:0] SVIEW_MASK = 64'h8000_0003_000D_E122;

    typedef struct packed {
        logic       sie;
        logic       mie;
        logic       spie;
        logic       mpie;
        logic       spp;
        logic [1:0] mpp;
        logic [1:0] fs;
        logic [1:0] xs;
        logic       mprv;
        logic       sum;
        logic       mxr;
        logic       tvm;
        logic       tw;
        logic       tsr;
        logic [1:0] uxl;
        logic [1:0] sxl;
    } mstat_t;

    function automatic logic [XLEN-1:0] pack_mstat(mstat_t s);
        logic [XLEN-1:0] r;
        r        = '0;
        r[1]     = s.sie;
        r[3]     = s.mie;
        r[5]     = s.spie;
        r[7]     = s.mpie;
        r[8]     = s.spp;
        r[12:11] = s.mpp;
        r[14:13] = s.fs;
        r[16:15] = s.xs;
        r[17]    = s.mprv;
        r[18]    = s.sum;
        r[19]    = s.mxr;
        r[20]    = s.tvm;
        r[21]    = s.tw;
        r[22]    = s.tsr;
        r[33:32] = s.uxl;
        r[35:34] = s.sxl;
        r[63]    = (s.fs == 2'b11) || (s.xs == 2'b11);
        return r;
    endfunction

endpackage

// File: rtl/csrst_status_reg.sv
module csrst_status_reg
    import csrst_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1,
    parameter bit HAS_UMODE = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] wr_img_i,
    input  ret_kind_e       ret_kind_i,
    output mstat_t          stat_o
);

    localparam logic [1:0] LOWEST_MODE = HAS_UMODE ? PRIV_U : PRIV_M;

    mstat_t stat_q;
    mstat_t stat_d;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_img_i[63:36], wr_img_i[31:23], wr_img_i[10:9],
                              wr_img_i[6], wr_img_i[4], wr_img_i[2], wr_img_i[0]};

    function automatic logic mpp_legal(logic [1:0] m);
        return (m == PRIV_M) || (HAS_SMODE && m == PRIV_S) || (HAS_UMODE && m == PRIV_U);
    endfunction

    function automatic mstat_t reset_value();
        mstat_t r;
        r     = '0;
        r.mpp = PRIV_M;
        r.sxl = HAS_SMODE ? XL_64 : 2'b00;
        r.uxl = HAS_UMODE ? XL_64 : 2'b00;
        return r;
    endfunction

    always_comb begin
        stat_d = stat_q;
        unique case (ret_kind_i)
            RET_NONE: begin
                if (wr_en_i) begin
                    stat_d.sie  = wr_img_i[1];
                    stat_d.mie  = wr_img_i[3];
                    stat_d.spie = wr_img_i[5];
                    stat_d.mpie = wr_img_i[7];
                    stat_d.spp  = wr_img_i[8];
                    if (mpp_legal(wr_img_i[12:11])) begin
                        stat_d.mpp = wr_img_i[12:11];
                    end
                    stat_d.fs   = wr_img_i[14:13];
                    stat_d.xs   = wr_img_i[16:15];
                    stat_d.mprv = wr_img_i[17];
                    stat_d.sum  = wr_img_i[18];
                    stat_d.mxr  = wr_img_i[19];
                    stat_d.tvm  = wr_img_i[20];
                    stat_d.tw   = wr_img_i[21];
                    stat_d.tsr  = wr_img_i[22];
                    if (wr_img_i[33:32] == XL_64) begin
                        stat_d.uxl = XL_64;
                    end
                    if (wr_img_i[35:34] == XL_64) begin
                        stat_d.sxl = XL_64;
                    end
                end
            end
            RET_M: begin
                stat_d.mie  = stat_q.mpie;
                stat_d.mpie = 1'b1;
                stat_d.mpp  = LOWEST_MODE;
                if (stat_q.mpp != PRIV_M) begin
                    stat_d.mprv = 1'b0;
                end
            end
            RET_S: begin
                stat_d.sie  = stat_q.spie;
                stat_d.spie = 1'b1;
                stat_d.spp  = 1'b0;
                stat_d.mprv = 1'b0;
            end
            default: begin
                stat_d = stat_q;
            end
        endcase

        if (!HAS_SMODE) begin
            stat_d.sie  = 1'b0;
            stat_d.spie = 1'b0;
            stat_d.spp  = 1'b0;
            stat_d.sum  = 1'b0;
            stat_d.mxr  = 1'b0;
            stat_d.tvm  = 1'b0;
            stat_d.tsr  = 1'b0;
            stat_d.sxl  = 2'b00;
        end
        if (!HAS_UMODE) begin
            stat_d.mprv = 1'b0;
            stat_d.uxl  = 2'b00;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= reset_value();
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/csrst_epc_reg.sv
module csrst_epc_reg
    import csrst_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] wr_data_i,
    output logic [XLEN-1:0] epc_o
);

    localparam logic [XLEN-1:0] ALIGN_MASK = ~{{(XLEN-1){1'b0}}, 1'b1};

    generate
        if (PRESENT) begin : g_store
            logic [XLEN-1:0] epc_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    epc_q <= '0;
                end else if (wr_en_i) begin
                    epc_q <= wr_data_i & ALIGN_MASK;
                end
            end
            assign epc_o = epc_q;
        end else begin : g_absent
            logic unused_epc_in;
            assign unused_epc_in = ^{clk_i, rst_ni, wr_en_i, wr_data_i};
            assign epc_o = '0;
        end
    endgenerate

endmodule

// File: rtl/csrst_read_mux.sv
module csrst_read_mux
    import csrst_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1
) (
    input  logic [11:0]     addr_i,
    input  logic [XLEN-1:0] mstat_img_i,
    input  logic [XLEN-1:0] mepc_i,
    input  logic [XLEN-1:0] sepc_i,
    output logic [XLEN-1:0] rdata_o
);

    always_comb begin
        unique case (addr_i)
            ADDR_MSTATUS: rdata_o = mstat_img_i;
            ADDR_SSTATUS: rdata_o = HAS_SMODE ? (mstat_img_i & SVIEW_MASK) : '0;
            ADDR_MEPC:    rdata_o = mepc_i;
            ADDR_SEPC:    rdata_o = sepc_i;
            ADDR_CFGPTR:  rdata_o = '0;
            default:      rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/csr_status_unit.sv
module csr_status_unit
    import csrst_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1,
    parameter bit HAS_UMODE = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [11:0]     csr_addr_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    input  logic            csr_we_i,
    input  logic            mret_i,
    input  logic            sret_i,
    input  logic [1:0]      priv_i,
    output logic [XLEN-1:0] csr_rdata_o,
    output logic [1:0]      ret_priv_o,
    output logic [XLEN-1:0] ret_pc_o
);

    ret_kind_e       ret_kind;
    mstat_t          mstat_q;
    logic [XLEN-1:0] mstat_img;
    logic [XLEN-1:0] stat_wr_img;
    logic            stat_wr_en;
    logic            we_eff;
    logic [XLEN-1:0] mepc_q;
    logic [XLEN-1:0] sepc_q;

    always_comb begin
        if (mret_i) begin
            ret_kind = RET_M;
        end else if (sret_i && HAS_SMODE) begin
            ret_kind = RET_S;
        end else begin
            ret_kind = RET_NONE;
        end
    end

    assign we_eff    = csr_we_i && !mret_i && !sret_i;
    assign mstat_img = pack_mstat(mstat_q);

    always_comb begin
        stat_wr_en  = 1'b0;
        stat_wr_img = mstat_img;
        if (we_eff && csr_addr_i == ADDR_MSTATUS) begin
            stat_wr_en  = 1'b1;
            stat_wr_img = csr_wdata_i;
        end else if (we_eff && HAS_SMODE && csr_addr_i == ADDR_SSTATUS) begin
            stat_wr_en  = 1'b1;
            stat_wr_img = (mstat_img & ~SVIEW_MASK) | (csr_wdata_i & SVIEW_MASK);
        end
    end

    csrst_status_reg #(
        .HAS_SMODE (HAS_SMODE),
        .HAS_UMODE (HAS_UMODE)
    ) u_status (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (stat_wr_en),
        .wr_img_i   (stat_wr_img),
        .ret_kind_i (ret_kind),
        .stat_o     (mstat_q)
    );

    csrst_epc_reg #(
        .PRESENT (1'b1)
    ) u_mepc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (we_eff && csr_addr_i == ADDR_MEPC),
        .wr_data_i (csr_wdata_i),
        .epc_o     (mepc_q)
    );

    csrst_epc_reg #(
        .PRESENT (HAS_SMODE)
    ) u_sepc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (we_eff && csr_addr_i == ADDR_SEPC),
        .wr_data_i (csr_wdata_i),
        .epc_o     (sepc_q)
    );

    csrst_read_mux #(
        .HAS_SMODE (HAS_SMODE)
    ) u_rmux (
        .addr_i      (csr_addr_i),
        .mstat_img_i (mstat_img),
        .mepc_i      (mepc_q),
        .sepc_i      (sepc_q),
        .rdata_o     (csr_rdata_o)
    );

    always_comb begin
        unique case (ret_kind)
            RET_M:   ret_priv_o = mstat_q.mpp;
            RET_S:   ret_priv_o = {1'b0, mstat_q.spp};
            default: ret_priv_o = priv_i;
        endcase
    end

    assign ret_pc_o = (ret_kind == RET_M) ? mepc_q : sepc_q;

endmodule

// File: rtl/csrst_checker.sv
module csrst_checker
    import csrst_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1,
    parameter bit HAS_UMODE = 1'b1
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [11:0]     csr_addr_i,
    input logic            csr_we_i,
    input logic            mret_i,
    input logic [XLEN-1:0] csr_rdata_o,
    input mstat_t          mstat_q
);

    localparam logic [1:0] LOWEST_MODE = HAS_UMODE ? PRIV_U : PRIV_M;
    localparam logic [1:0] SXL_EXP     = HAS_SMODE ? XL_64 : 2'b00;
    localparam logic [1:0] UXL_EXP     = HAS_UMODE ? XL_64 : 2'b00;

    a_r2_mie_from_mpie: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mret_i |=> (mstat_q.mie == $past(mstat_q.mpie)) && mstat_q.mpie && (mstat_q.mpp == LOWEST_MODE));

    a_r3_mprv_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mret_i && mstat_q.mpp != PRIV_M) |=> !mstat_q.mprv);

    a_r5_xl_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mstat_q.sxl == SXL_EXP) && (mstat_q.uxl == UXL_EXP));

    a_r6_epc_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == ADDR_MEPC || csr_addr_i == ADDR_SEPC) |-> !csr_rdata_o[0]);

    a_r7_cfgptr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == ADDR_CFGPTR) |-> (csr_rdata_o == '0));

    a_r8_be_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i == ADDR_MSTATUS) |-> (csr_rdata_o[37:36] == 2'b00) && !csr_rdata_o[6]);

    a_r11_mpp_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mstat_q.mpp != PRIV_RSV));

    a_r13_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mret_i && csr_we_i && csr_addr_i == ADDR_MSTATUS) |=> (mstat_q.mpp == LOWEST_MODE));

endmodule

bind csr_status_unit csrst_checker #(
    .HAS_SMODE (HAS_SMODE),
    .HAS_UMODE (HAS_UMODE)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .csr_addr_i  (csr_addr_i),
    .csr_we_i    (csr_we_i),
    .mret_i      (mret_i),
    .csr_rdata_o (csr_rdata_o),
    .mstat_q     (mstat_q)
);

// File: tb/csr_status_unit_tb_top.sv
`timescale 1ns/1ps
module csr_status_unit_tb_top;

    localparam int SEL_RD_A = 0;
    localparam int SEL_RD_B = 1;
    localparam int SEL_RP_A = 2;
    localparam int SEL_RP_B = 3;
    localparam int SEL_PC_A = 4;
    localparam int SEL_PC_B = 5;

    localparam logic [11:0] A_MST = 12'h300;
    localparam logic [11:0] A_SST = 12'h100;
    localparam logic [11:0] A_MEPC = 12'h341;
    localparam logic [11:0] A_SEPC = 12'h141;
    localparam logic [11:0] A_CFG = 12'hF15;

    typedef struct {
        int          sel;
        logic [63:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic        we = 1'b0;
    logic        mret = 1'b0;
    logic        sret = 1'b0;
    logic [1:0]  priv = 2'b11;

    logic [63:0] rd_a, rd_b, pc_a, pc_b;
    logic [1:0]  rp_a, rp_b;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;
    sb_item_t sb_q[$];
    event sample_ev;

    always #2 clk = ~clk;

    csr_status_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_we_i(we), .mret_i(mret), .sret_i(sret), .priv_i(priv),
        .csr_rdata_o(rd_a), .ret_priv_o(rp_a), .ret_pc_o(pc_a)
    );

    csr_status_unit #(.HAS_SMODE(1'b0), .HAS_UMODE(1'b0)) dut_m_i (
        .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_we_i(we), .mret_i(mret), .sret_i(sret), .priv_i(priv),
        .csr_rdata_o(rd_b), .ret_priv_o(rp_b), .ret_pc_o(pc_b)
    );

    // Monitor: pops expected items and compares with the live outputs
    always begin
        @(sample_ev);
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [63:0] act;
            it = sb_q.pop_front();
            case (it.sel)
                SEL_RD_A: act = rd_a;
                SEL_RD_B: act = rd_b;
                SEL_RP_A: act = {62'd0, rp_a};
                SEL_RP_B: act = {62'd0, rp_b};
                SEL_PC_A: act = pc_a;
                default:  act = pc_b;
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    task automatic push_exp(int sel, logic [63:0] exp, string tag);
        sb_item_t it;
        it.sel = sel;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic settle();
        -> sample_ev;
        #1;
    endtask

    task automatic wr(logic [11:0] a, logic [63:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, logic [63:0] ea, logic [63:0] eb, string tag);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1;
        push_exp(SEL_RD_A, ea, {tag, " full"});
        push_exp(SEL_RD_B, eb, {tag, " m-only"});
        settle();
    endtask

    task automatic xret(bit m, bit s, bit w, logic [63:0] d,
                        logic [1:0] pa, logic [1:0] pb,
                        logic [63:0] ca, logic [63:0] cb, string tag);
        @(negedge clk);
        mret = m; sret = s; we = w; addr = A_MST; wdata = d;
        #1;
        push_exp(SEL_RP_A, {62'd0, pa}, {tag, " priv full"});
        push_exp(SEL_RP_B, {62'd0, pb}, {tag, " priv m-only"});
        push_exp(SEL_PC_A, ca, {tag, " pc full"});
        push_exp(SEL_PC_B, cb, {tag, " pc m-only"});
        settle();
        @(negedge clk);
        mret = 1'b0; sret = 1'b0; we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_MST, 64'h0000000A_00001800, 64'h00000000_00001800, "R1 mstatus reset");
        rd(A_MEPC, 64'h0, 64'h0, "R1 mepc reset");

        // R6 return PCs drop bit 0; R12 sepc absent without S
        wr(A_MEPC, 64'h00000000_80001235);
        rd(A_MEPC, 64'h00000000_80001234, 64'h00000000_80001234, "R6 mepc bit0");
        wr(A_SEPC, 64'h4567);
        rd(A_SEPC, 64'h4566, 64'h0, "R6 R12 sepc bit0");

        // R7 configuration pointer
        wr(A_CFG, 64'hFFFF);
        rd(A_CFG, 64'h0, 64'h0, "R7 cfgptr");

        // R5 R8 R10 R12 all-ones write
        wr(A_MST, '1);
        rd(A_MST, 64'h8000000A_007FF9AA, 64'h80000000_0021F888, "R5 R8 R10 R12 all-ones");
        rd(A_SST, 64'h80000002_000DE122, 64'h0, "R9 R12 sstatus view");

        // R2 MRET with MPP=M keeps MPRV
        xret(1'b1, 1'b0, 1'b0, '0, 2'b11, 2'b11,
             64'h80001234, 64'h80001234, "R2 mret1");
        rd(A_MST, 64'h8000000A_007FE1AA, 64'h80000000_0021F888, "R2 R3 after mret1");

        // R3 MRET with MPP=U clears MPRV
        xret(1'b1, 1'b0, 1'b0, '0, 2'b00, 2'b11,
             64'h80001234, 64'h80001234, "R3 mret2");
        rd(A_MST, 64'h8000000A_007DE1AA, 64'h80000000_0021F888, "R3 after mret2");

        // R4 SRET
        xret(1'b0, 1'b1, 1'b0, '0, 2'b01, 2'b11,
             64'h4566, 64'h0, "R4 sret");
        rd(A_MST, 64'h8000000A_007DE0AA, 64'h80000000_0021F888, "R4 after sret");

        // R11 MPP legality
        wr(A_MST, 64'h0);
        rd(A_MST, 64'h0000000A_00000000, 64'h00000000_00001800, "R11 mpp U");
        wr(A_MST, 64'h800);
        rd(A_MST, 64'h0000000A_00000800, 64'h00000000_00001800, "R11 mpp S");
        wr(A_MST, 64'h1000);
        rd(A_MST, 64'h0000000A_00000800, 64'h00000000_00001800, "R11 mpp reserved");

        // R9 supervisor view write touches only its bits
        wr(A_SST, '1);
        rd(A_MST, 64'h8000000A_000DE922, 64'h00000000_00001800, "R9 sstatus write");

        // R10 SD from FS alone, then XS not dirty
        wr(A_MST, 64'h7800);
        rd(A_MST, 64'h8000000A_00007800, 64'h80000000_00007800, "R10 fs dirty");
        wr(A_MST, 64'h9800);
        rd(A_MST, 64'h0000000A_00009800, 64'h00000000_00009800, "R10 xs clean");

        // R13 write dropped under MRET
        xret(1'b1, 1'b0, 1'b1, 64'h0, 2'b11, 2'b11,
             64'h80001234, 64'h80001234, "R13 mret+write");
        rd(A_MST, 64'h0000000A_00008080, 64'h00000000_00009880, "R13 write dropped");

        // R13 MRET over SRET
        xret(1'b1, 1'b1, 1'b0, '0, 2'b00, 2'b11,
             64'h80001234, 64'h80001234, "R13 both strobes");
        rd(A_MST, 64'h0000000A_00008088, 64'h00000000_00009888, "R13 mret taken");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule